// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for a synchronous burst memory port. A single control line chooses between taking a fresh base address and stepping an open burst. When the line is low, the external 20-bit address is captured and the burst restarts at beat zero. When it is high, the beat index moves forward by one and only the two lowest address bits change. They follow one of two four-beat orderings that are picked at load time.

The two orderings are an exclusive-OR scheme and a modulo-four addition scheme. In the XOR scheme the low bits are the base low bits XOR the beat number. In the addition scheme the low bits are the base low bits plus the beat number, with any carry dropped. A clock enable freezes every register, so the memory port can stall in the middle of a burst. Both outputs come straight from registers and the values they hold, with no combinational path from any input.

Top module: `burst_addr_seq`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) sets the address output and the beat index to zero in the cycle that follows.
- R2: With clkEn high and loadN low at a rising edge, the next cycle shows the sampled baseAddr on curAddr and 0 on beatIdx.
- R3: With clkEn high and loadN high at a rising edge, beatIdx rises by one modulo 4. After beat 3 it returns to 0 and the address returns to the base address.
- R4: When the captured order bit is 1, the low two bits of curAddr equal the base low bits XOR beatIdx.
- R5: When the captured order bit is 0, the low two bits of curAddr equal (base low bits + beatIdx) modulo 4, with no carry into bit 2.
- R6: During an advance, curAddr bits [19:2] do not change.
- R7: orderSel is sampled only on a load. A change on orderSel during an advance has no effect on the ordering of the open burst.
- R8: With clkEn low at a rising edge, curAddr and beatIdx hold their values, and a load request or a new baseAddr on that edge is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| clkEn | input | 1 | Clock enable; low freezes all state |
| loadN | input | 1 | Low: load a new base; high: advance the burst |
| orderSel | input | 1 | Order captured at load: 1 = XOR order, 0 = linear order |
| baseAddr | input | 20 | External base address |
| curAddr | output | 20 | Current word address |
| beatIdx | output | 2 | Current beat within the burst |

## Verification
The bench loads every combination of the two low base bits under both orderings, with upper bits of all zeros, a mixed pattern and all ones. It then advances five times, so the wrap past beat 3 is covered. A linear scheme that let its carry reach bit 2 would corrupt the upper address with an all-ones base, and a wrap that failed to restore the base offset would show up on the fifth advance. During every burst orderSel is held at the opposite value, so a design that read the pin on advances instead of latching it at load would produce the wrong ordering. A stall is inserted with loadN low and a different address, so a clock enable that gated only part of the state would either reload or advance.

// File: rtl/bas_pkg.sv
package bas_pkg;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burstOrder_e;

  typedef struct packed {
    logic loadStb;
    logic advStb;
  } seqCtrl_t;

endpackage

// File: rtl/bas_ctrl.sv
module bas_ctrl
  import bas_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clkEn,
  input  logic              loadN,
  output seqCtrl_t          ctrl,
  output logic [BEAT_W-1:0] beatIdx
);

  logic [BEAT_W-1:0] beatQ;

  always_comb begin
    ctrl.loadStb = clkEn && !loadN;
    ctrl.advStb  = clkEn && loadN;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      beatQ <= '0;
    end else if (ctrl.loadStb) begin
      beatQ <= '0;
    end else if (ctrl.advStb) begin
      beatQ <= beatQ + BEAT_W'(1);
    end
  end

  assign beatIdx = beatQ;

endmodule

// File: rtl/bas_datapath.sv
module bas_datapath
  import bas_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  seqCtrl_t          ctrl,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic              orderSel,
  input  logic [BEAT_W-1:0] beatIdx,
  output logic [ADDR_W-1:0] curAddr
);

  localparam int HI_W = ADDR_W - BEAT_W;

  logic [ADDR_W-1:0] baseQ;
  burstOrder_e       modeQ;
  logic [BEAT_W-1:0] lowXor;
  logic [BEAT_W-1:0] lowAdd;
  logic [BEAT_W-1:0] lowSel;

  always_ff @(posedge clk) begin
    if (rst) begin
      baseQ <= '0;
      modeQ <= ORD_INTERLEAVE;
    end else if (ctrl.loadStb) begin
      baseQ <= baseAddr;
      modeQ <= burstOrder_e'(orderSel);
    end
  end

  // Each low bit in XOR order is independent of its neighbours
  for (genvar i = 0; i < BEAT_W; i++) begin : g_xorBit
    assign lowXor[i] = baseQ[i] ^ beatIdx[i];
  end

  // Linear order: sum truncated to the beat field, carry discarded
  assign lowAdd = baseQ[BEAT_W-1:0] + beatIdx;

  always_comb begin
    lowSel = (modeQ == ORD_INTERLEAVE) ? lowXor : lowAdd;
  end

  assign curAddr = {baseQ[ADDR_W-1 -: HI_W], lowSel};

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bas_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clkEn,
  input  logic              loadN,
  input  logic              orderSel,
  input  logic [ADDR_W-1:0] baseAddr,
  output logic [ADDR_W-1:0] curAddr,
  output logic [BEAT_W-1:0] beatIdx
);

  seqCtrl_t ctrl;

  bas_ctrl #(.BEAT_W(BEAT_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .clkEn   (clkEn),
    .loadN   (loadN),
    .ctrl    (ctrl),
    .beatIdx (beatIdx)
  );

  bas_datapath #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl),
    .baseAddr (baseAddr),
    .orderSel (orderSel),
    .beatIdx  (beatIdx),
    .curAddr  (curAddr)
  );

endmodule

// File: rtl/bas_chk.sv
module bas_chk #(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              clkEn,
  input logic              loadN,
  input logic [ADDR_W-1:0] baseAddr,
  input logic [ADDR_W-1:0] curAddr,
  input logic [BEAT_W-1:0] beatIdx
);

  logic seenClk = 1'b0;
  always_ff @(posedge clk) seenClk <= 1'b1;

  assert_reset_zero_R1: assert property (@(posedge clk)
    (seenClk && $past(rst)) |-> (curAddr == '0 && beatIdx == '0));

  assert_load_base_R2: assert property (@(posedge clk) disable iff (rst)
    (seenClk && !$past(rst) && $past(clkEn) && !$past(loadN))
      |-> (curAddr == $past(baseAddr) && beatIdx == '0));

  assert_beat_step_R3: assert property (@(posedge clk) disable iff (rst)
    (seenClk && !$past(rst) && $past(clkEn) && $past(loadN))
      |-> (beatIdx == BEAT_W'($past(beatIdx) + 1)));

  assert_upper_stable_R6: assert property (@(posedge clk) disable iff (rst)
    (seenClk && !$past(rst) && $past(clkEn) && $past(loadN))
      |-> $stable(curAddr[ADDR_W-1:BEAT_W]));

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (seenClk && !$past(rst) && !$past(clkEn))
      |-> ($stable(curAddr) && $stable(beatIdx)));

endmodule

bind burst_addr_seq bas_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .clkEn    (clkEn),
  .loadN    (loadN),
  .baseAddr (baseAddr),
  .curAddr  (curAddr),
  .beatIdx  (beatIdx)
);

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 200000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clkEn = 1'b1;
  logic        loadN = 1'b1;
  logic        orderSel = 1'b1;
  logic [19:0] baseAddr = '0;
  logic [19:0] curAddr;
  logic [1:0]  beatIdx;

  int checkCnt = 0;
  int failCnt  = 0;
  bit done     = 1'b0;

  logic [19:0] mBase = '0;
  logic        mMode = 1'b1;
  logic [1:0]  mBeat = '0;
  logic [19:0] mAddr = '0;

  burst_addr_seq u_burst_addr_seq (
    .clk      (clk),
    .rst      (rst),
    .clkEn    (clkEn),
    .loadN    (loadN),
    .orderSel (orderSel),
    .baseAddr (baseAddr),
    .curAddr  (curAddr),
    .beatIdx  (beatIdx)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [19:0] calcAddr(logic [19:0] b, logic m, logic [1:0] k);
    logic [1:0] lo;
    if (m) lo = b[1:0] ^ k;
    else   lo = 2'((int'(b[1:0]) + int'(k)) % 4);
    return {b[19:2], lo};
  endfunction

  task automatic step(input logic r, input logic en, input logic ld,
                      input logic ord, input logic [19:0] a);
    string tag;
    @(negedge clk);
    rst = r; clkEn = en; loadN = ld; orderSel = ord; baseAddr = a;
    if (r) begin
      tag = "R1"; mBase = '0; mMode = 1'b1; mBeat = '0;
    end else if (!en) begin
      tag = "R8";
    end else if (!ld) begin
      tag = "R2"; mBase = a; mMode = ord; mBeat = '0;
    end else begin
      mBeat = mBeat + 2'd1;
      if (ord != mMode) tag = mMode ? "R3/R4/R6/R7" : "R3/R5/R6/R7";
      else              tag = mMode ? "R3/R4/R6" : "R3/R5/R6";
    end
    mAddr = r ? '0 : calcAddr(mBase, mMode, mBeat);
    @(posedge clk);
    #1;
    checkCnt++;
    if (curAddr !== mAddr) begin
      failCnt++;
      $display("FAIL %s curAddr actual %h expected %h", tag, curAddr, mAddr);
    end
    checkCnt++;
    if (beatIdx !== mBeat) begin
      failCnt++;
      $display("FAIL %s beatIdx actual %0d expected %0d", tag, beatIdx, mBeat);
    end
  endtask

  initial begin
    logic [19:0] uppers [3];
    uppers[0] = 20'h00000;
    uppers[1] = 20'hA5C3C;
    uppers[2] = 20'hFFFFC;
    step(1'b1, 1'b1, 1'b1, 1'b1, 20'h0);
    step(1'b1, 1'b1, 1'b0, 1'b1, 20'h12345);
    for (int u = 0; u < 3; u++) begin
      for (int lo = 0; lo < 4; lo++) begin
        for (int m = 0; m < 2; m++) begin
          logic [19:0] b;
          b = uppers[u] | 20'(lo);
          step(1'b0, 1'b1, 1'b0, m[0], b);
          for (int k = 0; k < 5; k++) begin
            step(1'b0, 1'b1, 1'b1, ~m[0], ~b);
            if (k == 1) begin
              // stall with a competing load request and address
              step(1'b0, 1'b0, 1'b0, ~m[0], b ^ 20'h5A5A5);
              step(1'b0, 1'b0, 1'b1, m[0], 20'h0);
            end
          end
        end
      end
    end
    // reset from the middle of a burst
    step(1'b0, 1'b1, 1'b0, 1'b0, 20'h7FFFF);
    step(1'b0, 1'b1, 1'b1, 1'b0, 20'h0);
    step(1'b1, 1'b1, 1'b1, 1'b0, 20'h0);
    step(1'b0, 1'b1, 1'b1, 1'b0, 20'h0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog expired before completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

endmodule